// File: doc/BRIEF.md
# Serial Identifier Sender

This block answers a request strobe by sending a fixed identifier word on one serial output line, one bit per clock cycle, most significant bit first. Between transmissions the line rests at 0. The request comes from a source that has no fixed timing relation to the clock. It therefore passes through a synchronizer flop before the state logic sees it, and that flop adds one cycle of latency.

The controller is a Moore machine with a binary-coded state register. Code 0 is the resting state. Codes 1 to `ID_W` are the transmit states, and each of them drives one bit of the identifier. Any other code falls back to rest on the next edge. A transmit state advances on every edge whatever the request does. A request that is still high when the machine returns to rest starts a new word one cycle later. The identifier, its width and the synchronizer depth are parameters. The defaults are a 4-bit word `1101` and a single synchronizer flop, which gives a 3-bit state register.

Top module: `serial_id_sender`

## Requirements
- R1: A clock edge with `rst_n` low puts the block at rest (`id_bit` = 0) and clears the synchronizer. A request held high through reset therefore gives `id_bit` = 0 after the first edge with `rst_n` high, and the first identifier bit only after the second.
- R2: At rest, with the synchronized request low, the block stays at rest and `id_bit` stays 0.
- R3: A request sampled high at edge n, with the block at rest, makes the first identifier bit appear on `id_bit` after edge n+1.
- R4: A transmission puts `ID_PATTERN` bits `[ID_W-1]` down to `[0]` on `id_bit`, one clock cycle each. With the default pattern 4'b1101 the bits are 1, 1, 0, 1.
- R5: The edge after the last identifier bit returns the block to rest, and `id_bit` is 0 for at least that cycle.
- R6: A request that is high only while a transmission is in progress neither restarts nor lengthens it. The block stays at rest afterwards.
- R7: A request held high continuously produces words back to back with one rest cycle between them, a period of `ID_W`+1 cycles.
- R8: A request that is high for a single clock cycle is enough to start a full transmission.
- R9: Reset asserted in the middle of a transmission aborts it. `id_bit` is 0 after that edge, and the block stays at rest once reset is released if the request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_async | input | 1 | Request strobe from an unsynchronized source |
| id_bit | output | 1 | Serial identifier output, 0 when at rest |

## Verification
The hardest situations to reach from the ports are the ones where the request changes exactly as a transmission ends. In these cases the synchronized request must be sampled on the return to rest or on the cycle just after it, and because of the synchronizer the request has to be driven one cycle earlier than the state it affects. The bench sweeps every 10-cycle request pattern after a reset and drains each one. This puts request edges at every offset relative to every transmit state and to the rest cycle. A model built from the requirements predicts the output in each cycle. Directed sequences then cover a request held through reset, a reset in the middle of a word, and a request held high for several words.

// File: rtl/sid_pkg.sv
// Package: shared types and helpers for the serial identifier sender.
// Assumes state code 0 is the rest state and codes 1..ID_W are transmit states.
package sid_pkg;

    // Classification of a state code, used by the next-state logic.
    typedef enum logic [1:0] {
        PH_REST    = 2'd0,
        PH_SEND    = 2'd1,
        PH_FINAL   = 2'd2,
        PH_INVALID = 2'd3
    } phase_e;

    // Width of a state register that holds 0..n.
    function automatic int state_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sid_sync.sv
// Module: sid_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes STAGES >= 1. The synchronous active-low reset clears
// every stage, so nothing captured during reset survives its release.
module sid_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= 1'b0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            // Shift chain; the newest sample enters at bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sid_phase.sv
// Module: sid_phase
// Sorts a state code into rest, send, final-send or invalid.
// Assumes SW is wide enough to hold ID_W.
module sid_phase
    import sid_pkg::*;
#(
    parameter int ID_W = 4,
    parameter int SW   = 3
) (
    input  logic [SW-1:0] state,
    output phase_e        phase
);

    localparam logic [SW-1:0] LAST_CODE = SW'(ID_W);

    // Classify the current code.
    always_comb begin
        if (state == '0)             phase = PH_REST;
        else if (state == LAST_CODE) phase = PH_FINAL;
        else if (state < LAST_CODE)  phase = PH_SEND;
        else                         phase = PH_INVALID;
    end

endmodule

// File: rtl/sid_next.sv
// Module: sid_next
// Next-state logic. At rest it starts on a synchronized request. A send state
// always steps to the next code. The final and invalid codes go back to rest.
// Assumes the request input is already synchronized.
module sid_next
    import sid_pkg::*;
#(
    parameter int SW = 3
) (
    input  logic [SW-1:0] state,
    input  phase_e        phase,
    input  logic          req_sync,
    output logic [SW-1:0] state_nx
);

    localparam logic [SW-1:0] FIRST_CODE = SW'(1);

    // Choose the code for the next edge.
    always_comb begin
        unique case (phase)
            PH_REST:  state_nx = req_sync ? FIRST_CODE : '0;
            PH_SEND:  state_nx = state + FIRST_CODE;
            PH_FINAL: state_nx = '0;
            default:  state_nx = '0;
        endcase
    end

endmodule

// File: rtl/sid_bitsel.sv
// Module: sid_bitsel
// Output decode: transmit state k drives pattern bit ID_W-k, so the word goes
// out MSB first. Every other code drives 0. Assumes SW holds ID_W.
module sid_bitsel #(
    parameter int              ID_W    = 4,
    parameter int              SW      = 3,
    parameter logic [ID_W-1:0] PATTERN = 4'b1101
) (
    input  logic [SW-1:0] state,
    output logic          bit_o
);

    // Match the state against each transmit code.
    always_comb begin
        bit_o = 1'b0;
        for (int k = 1; k <= ID_W; k++) begin
            if (state == SW'(k)) bit_o = PATTERN[ID_W-k];
        end
    end

endmodule

// File: rtl/serial_id_sender.sv
// Module: serial_id_sender (top)
// Waits at rest until a synchronized request is seen, then sends ID_PATTERN
// MSB first, one bit per cycle, and returns to rest. Assumes a free-running
// clock and a synchronous active-low reset. req_async may change at any time.
module serial_id_sender #(
    parameter int                  ID_W        = 4,
    parameter logic [ID_W-1:0]     ID_PATTERN  = 4'b1101,
    parameter int                  SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic id_bit
);
    import sid_pkg::*;

    localparam int SW = state_width(ID_W);

    logic [SW-1:0] state_q;
    logic [SW-1:0] state_nx;
    logic          req_sync;
    phase_e        phase;

    sid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_async),
        .q_sync  (req_sync)
    );

    sid_phase #(.ID_W(ID_W), .SW(SW)) u_phase (
        .state (state_q),
        .phase (phase)
    );

    sid_next #(.SW(SW)) u_next (
        .state    (state_q),
        .phase    (phase),
        .req_sync (req_sync),
        .state_nx (state_nx)
    );

    sid_bitsel #(.ID_W(ID_W), .SW(SW), .PATTERN(ID_PATTERN)) u_bitsel (
        .state (state_q),
        .bit_o (id_bit)
    );

    // State register with synchronous reset to rest.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_nx;
    end

endmodule

// File: rtl/serial_id_sender_chk.sv
// Module: serial_id_sender_chk
// Checker bound to the top. It relates the state register, the synchronized
// request and the serial output across clock edges.
module serial_id_sender_chk #(
    parameter int ID_W = 4,
    parameter int SW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] state_q,
    input logic          req_sync,
    input logic          id_bit
);

    localparam logic [SW-1:0] LAST_CODE = SW'(ID_W);

    logic rst_was_low = 1'b0;

    // Remember whether reset was sampled low at the previous edge.
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // R1: after an edge with reset low, state and synchronizer are cleared.
    always @(posedge clk) begin
        if (rst_was_low) begin
            a_r1_reset_rest: assert (state_q == '0 && req_sync == 1'b0)
                else $error("a_r1_reset_rest");
        end
    end

    // R2: at rest with no synchronized request, stay at rest.
    a_r2_hold_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0 && !req_sync) |=> (state_q == '0));

    // R2: the line is 0 at rest.
    a_r2_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0) |-> !id_bit);

    // R3: a synchronized request at rest starts the first transmit state.
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0 && req_sync) |=> (state_q == SW'(1)));

    // R4, R6: transmit states advance one step regardless of the request.
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != '0 && state_q < LAST_CODE) |=> (state_q == $past(state_q) + SW'(1)));

    // R5: the final transmit state returns to rest.
    a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LAST_CODE) |=> (state_q == '0));

    // R4: the state register never holds a code beyond the last transmit state.
    a_r4_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q <= LAST_CODE));

endmodule

bind serial_id_sender serial_id_sender_chk #(.ID_W(ID_W), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .req_sync (req_sync),
    .id_bit   (id_bit)
);

// File: tb/serial_id_sender_bench.sv
// Bench: sweeps all 10-cycle request patterns against a model built from the
// requirements, then runs directed sequences for reset and hold cases.
module serial_id_sender_bench;

    localparam int              W   = 4;
    localparam logic [W-1:0]    PAT = 4'b1101;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic req   = 1'b0;
    logic id_bit;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Requirement model: rest count 0, transmit states 1..W.
    int m_cnt  = 0;
    bit m_sync = 1'b0;

    serial_id_sender u_serial_id_sender (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (req),
        .id_bit    (id_bit)
    );

    always #2 clk = ~clk;

    function automatic logic m_exp();
        return (m_cnt == 0) ? 1'b0 : PAT[W-m_cnt];
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive inputs, take one edge, update the model, sample away from the edge.
    task automatic tick(input logic r, input logic rn);
        req   = r;
        rst_n = rn;
        @(posedge clk);
        if (!rn) begin
            m_cnt  = 0;
            m_sync = 1'b0;
        end else begin
            if (m_cnt == 0)      m_cnt = m_sync ? 1 : 0;
            else if (m_cnt == W) m_cnt = 0;
            else                 m_cnt = m_cnt + 1;
            m_sync = r;
        end
        #1;
    endtask

    function automatic logic seq_bit(input int ph);
        return (ph == W) ? 1'b0 : PAT[W-1-ph];
    endfunction

    initial begin
        // Sweep over every 10-cycle request pattern (R2, R4..R8).
        for (int p = 0; p < 1024; p++) begin
            tick(1'b0, 1'b0);
            check("R1 reset", id_bit, 1'b0);
            for (int i = 0; i < 10; i++) begin
                tick(p[i], 1'b1);
                check((m_cnt == 0) ? "R2 rest" : "R4 word", id_bit, m_exp());
            end
            for (int i = 0; i < 6; i++) begin
                tick(1'b0, 1'b1);
                check((m_cnt == 0) ? "R5 rest after word" : "R4 word", id_bit, m_exp());
            end
        end

        // R1: request held through reset; synchronizer must be cleared.
        for (int i = 0; i < 3; i++) begin
            tick(1'b1, 1'b0);
            check("R1 in reset", id_bit, 1'b0);
        end
        tick(1'b1, 1'b1); check("R1 first edge after release", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R3 first bit", id_bit, PAT[3]);
        tick(1'b0, 1'b1); check("R4 bit 2", id_bit, PAT[2]);
        tick(1'b0, 1'b1); check("R4 bit 3", id_bit, PAT[1]);
        tick(1'b0, 1'b1); check("R4 bit 4", id_bit, PAT[0]);
        tick(1'b0, 1'b1); check("R5 back to rest", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R2 stays at rest", id_bit, 1'b0);

        // R8 single-cycle pulse, R6 request during the word is ignored.
        tick(1'b1, 1'b1); check("R8 pulse sampled", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R8 pulse starts word", id_bit, 1'b1);
        tick(1'b1, 1'b1); check("R6 bit 2", id_bit, 1'b1);
        tick(1'b1, 1'b1); check("R6 bit 3", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R6 bit 4", id_bit, 1'b1);
        tick(1'b0, 1'b1); check("R5 rest", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R6 no restart", id_bit, 1'b0);

        // R7: held request gives back-to-back words with one rest cycle.
        for (int k = 1; k <= 12; k++) begin
            tick(1'b1, 1'b1);
            check("R7 held request", id_bit, (k == 1) ? 1'b0 : seq_bit((k - 2) % (W + 1)));
        end
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b1);
        check("R2 drained", id_bit, 1'b0);

        // R9: reset in the middle of a word.
        tick(1'b1, 1'b1); check("R9 sample", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R9 bit 1", id_bit, 1'b1);
        tick(1'b0, 1'b1); check("R9 bit 2", id_bit, 1'b1);
        tick(1'b0, 1'b0); check("R9 abort", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R9 rest after release", id_bit, 1'b0);
        tick(1'b0, 1'b1); check("R2 rest", id_bit, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule